// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the power control state for a small 8-bit microcontroller core. A control register carries an idle request, a power-down request, two general-purpose flags and a bit that asks the serial port to double its baud rate. A separate 8-bit wake-mask register selects which interrupt sources may bring the device out of power-down. Software reaches both registers over a simple register bus: address, write strobe, write data and a combinational read-data return.

The block watches a vector of nine raw interrupt requests (sources 0 to 8) and the matching interrupt-enable bits. From the mode bits it drives two halt outputs. The CPU halt is raised in both idle and power-down. The peripheral halt, which stops the interrupt, timer and serial logic, is raised in power-down only. A wake event clears the matching mode bit on the next clock. Power-down wakes on any request whose mask bit is set, whatever its enable. Idle wakes only on an enabled request. Power-down takes precedence when both bits are set.

Top module: `lpm_ctrl`

## Requirements
- R1: After synchronous reset, the control and wake-mask registers read 0x00, and cpu_halt, periph_halt and baud_double are all 0. A reset in the same cycle as a register write wins over the write.
- R2: Control register layout: bit 7 is baud doubling, bit 3 is flag B, bit 2 is flag A, bit 1 is power-down and bit 0 is idle. Bits 6 to 4 always read 0, whatever was written to them.
- R3: baud_double equals control bit 7.
- R4: With only the idle bit set, cpu_halt is 1 and periph_halt is 0.
- R5: With the power-down bit set, cpu_halt and periph_halt are both 1. This holds whether or not the idle bit is also set.
- R6: Power-down ends, with bit 1 clearing on the next clock, when a request arrives on a source whose wake-mask bit is 1, even if that source is disabled. Mask bit 0 maps to source 0, and mask bit k (1 to 7) maps to source k+1. Source 1 never wakes power-down.
- R7: Idle ends, with bit 0 clearing on the next clock, only on a request whose enable bit is 1. A disabled request leaves idle set.
- R8: While power-down is set, a request that is enabled but not masked clears neither mode bit.
- R9: A control write in the same cycle as a wake event stores the written value, and the wake has no effect in that cycle.
- R10: The wake-mask register reads back what was written. A write to any address other than the two register addresses changes neither register, and such addresses read 0x00.
- R11: A wake event leaves the general-purpose flags and the doubling bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_req | input | 9 | Raw interrupt requests, sources 0..8 |
| irq_en | input | 9 | Interrupt enables, sources 0..8 |
| cpu_halt | output | 1 | CPU core halt |
| periph_halt | output | 1 | Interrupt, timer and serial halt |
| baud_double | output | 1 | Baud-doubling request to the serial port |

## Verification
The bench builds the block with a 6-bit address and the two registers placed at 0x07 and 0x1F instead of the defaults. This shows that the decode follows the parameters, and it leaves spare addresses such as 0x00 free for checks that writes there are ignored. With these values, every wake-mask bit is walked against its own source and against a neighbouring source, including the unmapped source 1. Both-modes precedence, a write racing a wake, and a reset racing a write are each driven in the exact cycle where the two meet.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int NSRC   = 9;
    localparam int MASK_W = 8;

    typedef struct packed {
        logic       dbl;
        logic [2:0] rsv;
        logic       flag_b;
        logic       flag_a;
        logic       pdn;
        logic       idle;
    } ctrl_t;

    typedef struct packed {
        logic pdn_wake;
        logic idle_wake;
    } wake_t;

    // Spread the 8 mask bits over 9 sources; source 1 has no mask bit.
    function automatic logic [NSRC-1:0] spread_mask(input logic [MASK_W-1:0] m);
        logic [NSRC-1:0] v;
        v    = '0;
        v[0] = m[0];
        for (int k = 1; k < MASK_W; k++) begin
            v[k+1] = m[k];
        end
        return v;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
        return {c.dbl, 3'b000, c.flag_b, c.flag_a, c.pdn, c.idle};
    endfunction

endpackage

// File: rtl/lpm_wake.sv
module lpm_wake
    import lpm_pkg::*;
(
    input  logic [NSRC-1:0]   irq_req,
    input  logic [NSRC-1:0]   irq_en,
    input  logic [MASK_W-1:0] wake_mask,
    input  logic              pdn_q,
    input  logic              idle_q,
    output wake_t             wake
);
    logic [NSRC-1:0] mask_vec;

    always_comb begin
        mask_vec       = spread_mask(wake_mask);
        wake.pdn_wake  = pdn_q & (|(irq_req & mask_vec));
        // Interrupt logic is stopped during power-down, so idle cannot end then.
        wake.idle_wake = idle_q & ~pdn_q & (|(irq_req & irq_en));
    end
endmodule

// File: rtl/lpm_regs.sv
module lpm_regs
    import lpm_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h20,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  wake_t             wake,
    output ctrl_t             ctrl_q,
    output logic [MASK_W-1:0] mask_q
);
    logic ctrl_hit, mask_hit;

    assign ctrl_hit = bus_we && (bus_addr == CTRL_ADDR);
    assign mask_hit = bus_we && (bus_addr == MASK_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else begin
            if (ctrl_hit) begin
                ctrl_q.dbl    <= bus_wdata[7];
                ctrl_q.rsv    <= 3'b000;
                ctrl_q.flag_b <= bus_wdata[3];
                ctrl_q.flag_a <= bus_wdata[2];
                ctrl_q.pdn    <= bus_wdata[1];
                ctrl_q.idle   <= bus_wdata[0];
            end else begin
                if (wake.pdn_wake)  ctrl_q.pdn  <= 1'b0;
                if (wake.idle_wake) ctrl_q.idle <= 1'b0;
            end
            if (mask_hit) begin
                mask_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        if (bus_addr == CTRL_ADDR)      bus_rdata = ctrl_to_byte(ctrl_q);
        else if (bus_addr == MASK_ADDR) bus_rdata = mask_q;
        else                            bus_rdata = 8'h00;
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h20,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [8:0]        irq_req,
    input  logic [8:0]        irq_en,
    output logic              cpu_halt,
    output logic              periph_halt,
    output logic              baud_double
);
    ctrl_t             ctrl_q;
    logic [MASK_W-1:0] mask_q;
    wake_t             wake;

    lpm_regs #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .MASK_ADDR(MASK_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .wake     (wake),
        .ctrl_q   (ctrl_q),
        .mask_q   (mask_q)
    );

    lpm_wake u_wake (
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .wake_mask(mask_q),
        .pdn_q    (ctrl_q.pdn),
        .idle_q   (ctrl_q.idle),
        .wake     (wake)
    );

    always_comb begin
        periph_halt = ctrl_q.pdn;
        cpu_halt    = ctrl_q.pdn | ctrl_q.idle;
        baud_double = ctrl_q.dbl;
    end
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
    import lpm_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h20
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [8:0]        irq_req,
    input logic [8:0]        irq_en,
    input logic [MASK_W-1:0] mask_q,
    input logic              cpu_halt,
    input logic              periph_halt,
    input logic              baud_double
);
    logic ctrl_wr, masked_req, enabled_req;
    assign ctrl_wr     = bus_we && (bus_addr == CTRL_ADDR);
    assign masked_req  = |(irq_req & spread_mask(mask_q));
    assign enabled_req = |(irq_req & irq_en);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!cpu_halt && !periph_halt && !baud_double));

    a_r5_pdn_halts_cpu: assert property (@(posedge clk) disable iff (rst)
        periph_halt |-> cpu_halt);

    a_r6_pdn_wake: assert property (@(posedge clk) disable iff (rst)
        (periph_halt && masked_req && !ctrl_wr) |=> !periph_halt);

    a_r8_pdn_holds: assert property (@(posedge clk) disable iff (rst)
        (periph_halt && !masked_req && !ctrl_wr) |=> periph_halt);

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (cpu_halt && !periph_halt && !enabled_req && !ctrl_wr) |=> cpu_halt);

    a_r3_dbl_stable: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(baud_double));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .irq_req    (irq_req),
    .irq_en     (irq_en),
    .mask_q     (mask_q),
    .cpu_halt   (cpu_halt),
    .periph_halt(periph_halt),
    .baud_double(baud_double)
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam logic [AW-1:0] CA = 6'h07;
    localparam logic [AW-1:0] MA = 6'h1F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [8:0]    irq_req = '0;
    logic [8:0]    irq_en = '0;
    logic          cpu_halt, periph_halt, baud_double;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_ctrl #(.ADDR_W(AW), .CTRL_ADDR(CA), .MASK_ADDR(MA)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .irq_en(irq_en), .cpu_halt(cpu_halt), .periph_halt(periph_halt),
        .baud_double(baud_double)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic pulse(input logic [8:0] req, input logic [8:0] en);
        @(negedge clk);
        irq_req = req; irq_en = en;
        @(negedge clk);
        irq_req = '0; irq_en = '0;
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", CA, 8'h00);
        rd_chk("R1 mask", MA, 8'h00);
        chk("R1 halts", {5'd0, cpu_halt, periph_halt, baud_double}, 8'h00);
    endtask

    task automatic t_fields;
        wr(CA, 8'hFF);
        rd_chk("R2 reserved read 0", CA, 8'h8F);
        chk("R3 dbl on", {7'd0, baud_double}, 8'h01);
        chk("R5 pdn halts", {6'd0, cpu_halt, periph_halt}, 8'h03);
        wr(CA, 8'h0C);
        rd_chk("R2 flags", CA, 8'h0C);
        chk("R3 dbl off", {7'd0, baud_double}, 8'h00);
    endtask

    task automatic t_idle;
        wr(CA, 8'h01);
        chk("R4 idle halts", {6'd0, cpu_halt, periph_halt}, 8'h02);
        pulse(9'h010, 9'h000);
        rd_chk("R7 disabled no wake", CA, 8'h01);
        pulse(9'h010, 9'h010);
        rd_chk("R7 enabled wake", CA, 8'h00);
        chk("R7 halts off", {6'd0, cpu_halt, periph_halt}, 8'h00);
    endtask

    task automatic t_map;
        for (int k = 0; k < 8; k++) begin
            int src  = (k == 0) ? 0 : k + 1;
            int kn   = (k + 1) % 8;
            int oth  = (kn == 0) ? 0 : kn + 1;
            wr(MA, 8'(1 << k));
            rd_chk("R10 mask readback", MA, 8'(1 << k));
            wr(CA, 8'h02);
            pulse(9'(1 << oth), 9'h000);
            rd_chk("R6 other src no wake", CA, 8'h02);
            pulse(9'h002, 9'h1FF);
            rd_chk("R6 src1 never wakes", CA, 8'h02);
            pulse(9'(1 << src), 9'h000);
            rd_chk("R6 masked disabled wakes", CA, 8'h00);
        end
    endtask

    task automatic t_both;
        wr(MA, 8'h00);
        wr(CA, 8'h03);
        chk("R5 both pdn wins", {6'd0, cpu_halt, periph_halt}, 8'h03);
        pulse(9'h008, 9'h1FF);
        rd_chk("R8 enabled unmasked held", CA, 8'h03);
        wr(MA, 8'h04);
        pulse(9'h008, 9'h000);
        rd_chk("R6 pdn cleared idle kept", CA, 8'h01);
        chk("R4 after pdn exit", {6'd0, cpu_halt, periph_halt}, 8'h02);
        pulse(9'h008, 9'h008);
        rd_chk("R7 idle exit", CA, 8'h00);
    endtask

    task automatic t_race;
        wr(MA, 8'h01);
        wr(CA, 8'h02);
        @(negedge clk);
        bus_addr = CA; bus_we = 1'b1; bus_wdata = 8'h06; irq_req = 9'h001;
        @(negedge clk);
        bus_we = 1'b0; irq_req = '0;
        rd_chk("R9 write beats wake", CA, 8'h06);
        @(negedge clk);
        rst = 1'b1; bus_addr = MA; bus_we = 1'b1; bus_wdata = 8'hAA;
        @(negedge clk);
        rst = 1'b0; bus_we = 1'b0;
        rd_chk("R1 reset beats write mask", MA, 8'h00);
        rd_chk("R1 reset ctrl", CA, 8'h00);
    endtask

    task automatic t_flags;
        wr(CA, 8'h8D);
        pulse(9'h100, 9'h100);
        rd_chk("R11 flags kept", CA, 8'h8C);
        chk("R11 dbl kept", {7'd0, baud_double}, 8'h01);
    endtask

    task automatic t_decode;
        wr(MA, 8'h5A);
        wr(6'h00, 8'hFF);
        rd_chk("R10 stray write ctrl", CA, 8'h8C);
        rd_chk("R10 stray write mask", MA, 8'h5A);
        rd_chk("R10 stray read", 6'h00, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fields();
        t_idle();
        t_map();
        t_both();
        t_race();
        t_flags();
        t_decode();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule